// File: doc/BRIEF.md
# Multidrop Address Wake-up Receiver

This block is the character layer of a serial receiver for multiprocessor links. Here one master talks to many stations over a shared line. A frame is received one bit per `bit_tick` strobe. The strobe comes from an external baud generator and already sits at mid-bit. When multidrop operation is selected, each frame carries a ninth bit after the data. This bit marks the character as a station address (1) or as payload data (0).

A station normally keeps its receiver disabled, but it still watches every frame on the line. Every address character reaches the holding register, raises the ready flag and, if enabled, the interrupt. Software can then compare the address with its own and enable the receiver. Alternatively, the auto-match mode makes the block itself set or clear the receiver enable by comparing against `station_addr`. Data characters are delivered only while the receiver is enabled. A new address always starts a new data field. With multidrop off, the block is a plain receiver: it has no ninth bit and delivers characters while enabled.

Top module: `mdr_wakeup_rx`

## Requirements
- R1: After reset, `rx_ready`, `rx_enabled`, `rx_is_addr` and `irq` are 0 and `rx_data` is 0.
- R2: A frame is sampled on `bit_tick` strobes and has these bits in order: a start bit of 0, 8 data bits with the LSB first, the flag bit (only when multidrop is on), and a stop bit. A frame whose stop bit is 0 is dropped and leaves `rx_data` and `rx_is_addr` unchanged. The mode used for a frame is `md_en` as sampled at its start bit.
- R3: With multidrop off, a good frame is delivered only while `rx_enabled` is 1. Delivery loads `rx_data`, clears `rx_is_addr` and sets `rx_ready`.
- R4: With multidrop on, a good frame with flag bit 1 is an address. It is always delivered, whether the receiver is enabled or not, and it sets `rx_ready` and `rx_is_addr`.
- R5: With multidrop on, a data frame (flag bit 0) received while `rx_enabled` is 0 is ignored. `rx_ready`, `rx_data` and `rx_is_addr` keep their values.
- R6: With multidrop on, a data frame received while `rx_enabled` is 1 is delivered, with `rx_is_addr` 0.
- R7: When `auto_match` is 1, a delivered address sets `rx_enabled` if it equals `station_addr` and clears it otherwise. This update takes precedence over `en_set` and `en_clr` in the same cycle.
- R8: Outside an auto-match update, `en_clr` clears `rx_enabled` and `en_set` sets it. `en_clr` wins when both are high. With `auto_match` at 0, addresses leave `rx_enabled` unchanged.
- R9: `rd_ack` clears `rx_ready`, unless a character is delivered in the same cycle, in which case `rx_ready` stays 1.
- R10: `irq` is 1 exactly when `rx_ready` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at the middle of each bit period |
| rxd | input | 1 | Serial line, idle high |
| md_en | input | 1 | Multidrop mode select |
| auto_match | input | 1 | Hardware address comparison enable |
| station_addr | input | 8 | This station's address |
| irq_en | input | 1 | Interrupt enable |
| en_set | input | 1 | Software pulse that enables the receiver |
| en_clr | input | 1 | Software pulse that disables the receiver |
| rd_ack | input | 1 | Holding register read, clears ready |
| rx_data | output | 8 | Holding register |
| rx_is_addr | output | 1 | Holding register contains an address |
| rx_ready | output | 1 | A character is waiting |
| rx_enabled | output | 1 | Receiver enable state |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cases where enable and delivery interact.

- **Data while disabled.** A design that delivered such data would overwrite the stored address.
- **Address while already enabled.** A design that gated addresses on the enable would lose the start of the next data field.
- **Auto-match on an equal and an unequal address, with `en_clr` held in the same cycle.** A design with the wrong priority would leave the station deaf after a matching address.
- **Read acknowledge coinciding with delivery, and a bad stop bit.** A design that got these wrong would drop a ready flag or latch a corrupt character.
- **Asymmetric byte values.** These expose a reversed bit order.

// File: rtl/mdr_pkg.sv
// Shared types for the multidrop wake-up receiver.
// Assumes one frame is in flight at a time and that the bit strobe is already mid-bit.
package mdr_pkg;

    // Deserializer phase within a frame
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_FLAG = 2'd2,
        PH_STOP = 2'd3
    } mdr_phase_e;

    // Qualifiers that travel with each completed character
    typedef struct packed {
        logic flag;     // address marker (already masked by mode)
        logic stop_ok;  // stop bit sampled high
        logic md;       // frame was received in multidrop mode
    } mdr_tag_t;

endpackage

// File: rtl/mdr_deser.sv
// Frame deserializer: start bit, DATA_W data bits LSB first, optional flag bit, stop bit.
// Emits a one-cycle cv_valid with the character and its qualifiers on the stop strobe.
// Assumes bit_tick pulses once per bit period at mid-bit.
module mdr_deser
    import mdr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rxd,
    input  logic              md_en,
    output logic              cv_valid,
    output logic [DATA_W-1:0] cv_data,
    output mdr_tag_t          cv_tag
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    mdr_phase_e        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic              md_q;
    logic              flag_q;

    // Walk through the frame phases and capture bits on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            shift_q  <= '0;
            md_q     <= 1'b0;
            flag_q   <= 1'b0;
            cv_valid <= 1'b0;
            cv_data  <= '0;
            cv_tag   <= '0;
        end else begin
            cv_valid <= 1'b0;
            if (bit_tick) begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (!rxd) begin
                            phase_q <= PH_DATA;
                            cnt_q   <= '0;
                            md_q    <= md_en;
                            flag_q  <= 1'b0;
                        end
                    end
                    PH_DATA: begin
                        shift_q <= {rxd, shift_q[DATA_W-1:1]};
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            phase_q <= md_q ? PH_FLAG : PH_STOP;
                        end
                    end
                    PH_FLAG: begin
                        flag_q  <= rxd;
                        phase_q <= PH_STOP;
                    end
                    PH_STOP: begin
                        cv_valid       <= 1'b1;
                        cv_data        <= shift_q;
                        cv_tag.flag    <= md_q & flag_q;
                        cv_tag.stop_ok <= rxd;
                        cv_tag.md      <= md_q;
                        phase_q        <= PH_IDLE;
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mdr_filter.sv
// Acceptance filter: decides whether a completed character is delivered and
// maintains the receiver-enable state (software pulses or hardware address match).
// Assumes cv_* is a one-cycle pulse from the deserializer.
module mdr_filter
    import mdr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cv_valid,
    input  logic [DATA_W-1:0] cv_data,
    input  mdr_tag_t          cv_tag,
    input  logic              auto_match,
    input  logic [DATA_W-1:0] station_addr,
    input  logic              en_set,
    input  logic              en_clr,
    output logic              accept,
    output logic              rx_enabled
);
    logic good_frame;
    logic addr_frame;
    logic rx_en_q;

    // Classify the current character and decide on delivery
    always_comb begin
        good_frame = cv_valid & cv_tag.stop_ok;
        addr_frame = good_frame & cv_tag.md & cv_tag.flag;
        accept     = good_frame & (addr_frame | rx_en_q);
    end

    // Receiver enable: hardware match first, then clear, then set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q <= 1'b0;
        end else if (addr_frame && auto_match) begin
            rx_en_q <= (cv_data == station_addr);
        end else if (en_clr) begin
            rx_en_q <= 1'b0;
        end else if (en_set) begin
            rx_en_q <= 1'b1;
        end
    end

    assign rx_enabled = rx_en_q;

endmodule

// File: rtl/mdr_hold.sv
// Holding register with ready flag and interrupt request.
// Assumes accept is at most one cycle per character.
module mdr_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] cv_data,
    input  logic              addr_flag,
    input  logic              rd_ack,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_is_addr,
    output logic              rx_ready,
    output logic              irq
);
    // Load on delivery; otherwise a read clears the ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_is_addr <= 1'b0;
            rx_ready   <= 1'b0;
        end else if (accept) begin
            rx_data    <= cv_data;
            rx_is_addr <= addr_flag;
            rx_ready   <= 1'b1;
        end else if (rd_ack) begin
            rx_ready   <= 1'b0;
        end
    end

    // Interrupt follows ready when enabled
    always_comb begin
        irq = rx_ready & irq_en;
    end

endmodule

// File: rtl/mdr_wakeup_rx.sv
// Multidrop wake-up receiver top: deserializer, acceptance filter, holding register.
// Assumes an external baud generator supplies bit_tick at mid-bit.
module mdr_wakeup_rx
    import mdr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rxd,
    input  logic              md_en,
    input  logic              auto_match,
    input  logic [DATA_W-1:0] station_addr,
    input  logic              irq_en,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_is_addr,
    output logic              rx_ready,
    output logic              rx_enabled,
    output logic              irq
);
    logic              cv_valid;
    logic [DATA_W-1:0] cv_data;
    mdr_tag_t          cv_tag;
    logic              accept;

    mdr_deser #(.DATA_W(DATA_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .rxd      (rxd),
        .md_en    (md_en),
        .cv_valid (cv_valid),
        .cv_data  (cv_data),
        .cv_tag   (cv_tag)
    );

    mdr_filter #(.DATA_W(DATA_W)) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .cv_valid     (cv_valid),
        .cv_data      (cv_data),
        .cv_tag       (cv_tag),
        .auto_match   (auto_match),
        .station_addr (station_addr),
        .en_set       (en_set),
        .en_clr       (en_clr),
        .accept       (accept),
        .rx_enabled   (rx_enabled)
    );

    mdr_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cv_data    (cv_data),
        .addr_flag  (cv_tag.flag),
        .rd_ack     (rd_ack),
        .irq_en     (irq_en),
        .rx_data    (rx_data),
        .rx_is_addr (rx_is_addr),
        .rx_ready   (rx_ready),
        .irq        (irq)
    );

endmodule

// File: rtl/mdr_wakeup_rx_chk.sv
// Assertion checker for the multidrop wake-up receiver, bound into the top.
// Assumes the deserializer output pulse is visible one cycle before the holding update.
module mdr_wakeup_rx_chk
    import mdr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cv_valid,
    input logic [DATA_W-1:0] cv_data,
    input mdr_tag_t          cv_tag,
    input logic              auto_match,
    input logic [DATA_W-1:0] station_addr,
    input logic              irq_en,
    input logic              en_clr,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_is_addr,
    input logic              rx_ready,
    input logic              rx_enabled,
    input logic              irq
);
    // R2
    bad_stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_valid && !cv_tag.stop_ok) |=> ($stable(rx_data) && $stable(rx_is_addr)));

    // R4
    addr_delivered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_valid && cv_tag.stop_ok && cv_tag.md && cv_tag.flag)
        |=> (rx_ready && rx_is_addr && rx_data == $past(cv_data)));

    // R5
    data_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_valid && cv_tag.md && !cv_tag.flag && !rx_enabled)
        |=> ($stable(rx_data) && $stable(rx_is_addr)));

    // R7
    auto_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_valid && cv_tag.stop_ok && cv_tag.md && cv_tag.flag && auto_match)
        |=> (rx_enabled == ($past(cv_data) == $past(station_addr))));

    // R8
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && !(cv_valid && cv_tag.stop_ok && cv_tag.md && cv_tag.flag && auto_match))
        |=> !rx_enabled);

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !cv_valid) |=> !rx_ready);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && rx_ready));

endmodule

bind mdr_wakeup_rx mdr_wakeup_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cv_valid     (cv_valid),
    .cv_data      (cv_data),
    .cv_tag       (cv_tag),
    .auto_match   (auto_match),
    .station_addr (station_addr),
    .irq_en       (irq_en),
    .en_clr       (en_clr),
    .rd_ack       (rd_ack),
    .rx_data      (rx_data),
    .rx_is_addr   (rx_is_addr),
    .rx_ready     (rx_ready),
    .rx_enabled   (rx_enabled),
    .irq          (irq)
);

// File: tb/tb_mdr_wakeup_rx.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module tb_mdr_wakeup_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       md_en = 1'b0;
    logic       auto_match = 1'b0;
    logic [7:0] station_addr = 8'h00;
    logic       irq_en = 1'b0;
    logic       en_set = 1'b0;
    logic       en_clr = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_is_addr, rx_ready, rx_enabled, irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mdr_wakeup_rx dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd), .md_en(md_en),
        .auto_match(auto_match), .station_addr(station_addr), .irq_en(irq_en),
        .en_set(en_set), .en_clr(en_clr), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_is_addr(rx_is_addr), .rx_ready(rx_ready),
        .rx_enabled(rx_enabled), .irq(irq)
    );

    // Reference model state
    int  m_phase = 0;   // 0 idle, 1 data, 2 flag, 3 stop
    int  m_nbits = 0;
    int  m_byte = 0;
    bit  m_md = 0, m_flag = 0;
    bit  pend = 0, p_ok = 0, p_md = 0, p_flag = 0;
    int  p_byte = 0;
    bit  e_ready = 0, e_addr = 0, e_en = 0;
    int  e_data = 0;

    always @(posedge clk) begin
        bit good, isa, acc;
        if (!rst_n) begin
            m_phase = 0; pend = 0; e_ready = 0; e_addr = 0; e_en = 0; e_data = 0;
        end else begin
            good = pend && p_ok;
            isa  = good && p_md && p_flag;
            acc  = good && (isa || e_en);
            if (acc) begin
                e_data = p_byte; e_addr = isa; e_ready = 1;
            end else if (rd_ack) e_ready = 0;
            if (isa && auto_match) e_en = (p_byte == int'(station_addr));
            else if (en_clr) e_en = 0;
            else if (en_set) e_en = 1;
            pend = 0;
            if (bit_tick) begin
                if (m_phase == 0) begin
                    if (!rxd) begin m_phase = 1; m_nbits = 0; m_byte = 0; m_md = md_en; m_flag = 0; end
                end else if (m_phase == 1) begin
                    if (rxd) m_byte = m_byte + (1 << m_nbits);
                    m_nbits++;
                    if (m_nbits == 8) m_phase = m_md ? 2 : 3;
                end else if (m_phase == 2) begin
                    m_flag = rxd; m_phase = 3;
                end else begin
                    pend = 1; p_ok = rxd; p_md = m_md; p_flag = m_md && m_flag; p_byte = m_byte;
                    m_phase = 0;
                end
            end
        end
    end

    // Compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (rx_ready !== e_ready) begin fails++; $display("FAIL R9 model rx_ready act=%0d exp=%0d", rx_ready, e_ready); end
            if (int'(rx_data) != e_data) begin fails++; $display("FAIL R3 model rx_data act=%0h exp=%0h", rx_data, e_data); end
            if (rx_is_addr !== e_addr) begin fails++; $display("FAIL R4 model rx_is_addr act=%0d exp=%0d", rx_is_addr, e_addr); end
            if (rx_enabled !== e_en) begin fails++; $display("FAIL R7 model rx_enabled act=%0d exp=%0d", rx_enabled, e_en); end
            if (irq !== (e_ready && irq_en)) begin fails++; $display("FAIL R10 model irq act=%0d exp=%0d", irq, e_ready && irq_en); end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); rxd = b; bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
        @(negedge clk);
    endtask

    // Returns at the negedge right after the holding register update
    task automatic send_frame(input logic [7:0] d, input bit flag, input bit stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (md_en) send_bit(flag);
        send_bit(stop);
        rxd = 1'b1;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", rx_ready, 0);
        chk("R1 enabled", rx_enabled, 0);
        chk("R1 data", rx_data, 0);
        chk("R1 irq/is_addr", {irq, rx_is_addr}, 0);

        send_frame(8'h1E, 0, 1);
        chk("R3 disabled plain ignored", rx_ready, 0);
        pulse(en_set);
        chk("R8 en_set", rx_enabled, 1);
        send_frame(8'h1E, 0, 1);
        chk("R3 ready", rx_ready, 1);
        chk("R2 LSB-first data", rx_data, 8'h1E);
        chk("R3 is_addr", rx_is_addr, 0);
        chk("R10 irq off", irq, 0);
        @(negedge clk); irq_en = 1'b1; #1;
        chk("R10 irq on", irq, 1);
        pulse(rd_ack);
        chk("R9 rd_ack clears", rx_ready, 0);
        chk("R10 irq drops", irq, 0);

        send_frame(8'h33, 0, 0);
        chk("R2 bad stop ready", rx_ready, 0);
        chk("R2 bad stop data", rx_data, 8'h1E);

        md_en = 1'b1;
        pulse(en_clr);
        chk("R8 en_clr", rx_enabled, 0);
        send_frame(8'h11, 0, 1);
        chk("R5 data ignored ready", rx_ready, 0);
        chk("R5 data ignored data", rx_data, 8'h1E);
        send_frame(8'h42, 1, 1);
        chk("R4 addr ready", rx_ready, 1);
        chk("R4 addr data", rx_data, 8'h42);
        chk("R4 addr flag", rx_is_addr, 1);
        chk("R8 no auto keeps enable", rx_enabled, 0);
        pulse(rd_ack);

        auto_match = 1'b1; station_addr = 8'h42;
        send_frame(8'h42, 1, 1);
        chk("R7 match enables", rx_enabled, 1);
        send_frame(8'h77, 0, 1);
        chk("R6 data delivered", rx_data, 8'h77);
        chk("R6 data not addr", rx_is_addr, 0);
        send_frame(8'h43, 1, 1);
        chk("R4 addr while enabled", rx_data, 8'h43);
        chk("R7 mismatch disables", rx_enabled, 0);
        send_frame(8'h99, 0, 1);
        chk("R5 dropped after mismatch", rx_data, 8'h43);

        pulse(rd_ack);
        rd_ack = 1'b1;
        send_frame(8'h10, 1, 1);
        rd_ack = 1'b0;
        chk("R9 delivery beats rd_ack", rx_ready, 1);

        en_clr = 1'b1;
        send_frame(8'h42, 1, 1);
        en_clr = 1'b0;
        chk("R7 match beats en_clr", rx_enabled, 1);

        md_en = 1'b0;
        send_frame(8'hC3, 0, 1);
        chk("R3 plain after multidrop", rx_data, 8'hC3);
        chk("R3 plain is_addr", rx_is_addr, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule